// File: doc/BRIEF.md
# Replicated Register Steering Fabric

This block holds many copies of one control register, all reached through a single bus offset. Each copy belongs to a unit named by a group number and an instance number. A steering selector register picks the copy that a unicast access reaches and holds a multicast flag. A write to the data offset with the flag set updates every copy at once. With the flag clear, the write reaches only the selected copy. A read always returns exactly one copy, whatever the flag holds.

A per-copy present mask input marks units that are fused off or power-gated. Reads steered to such a unit return zero, and unicast writes steered to it are dropped. A hardware semaphore decides which of several requesters may reprogram the selector. A requester takes it by reading the semaphore offset and seeing 1. It gives it back by writing 1 to that offset.

The bus is a single-cycle request port: every request is accepted in the cycle it is presented, and it is answered with a one-cycle response pulse on the following cycle.

Top module: `steer_fabric`

## Requirements
- R1: After reset the selector holds multicast set with group 0 and instance 0, the semaphore is free, and `rsp_valid` is low.
- R2: A write to offset 0 while the multicast flag is set stores the same value into every copy. This includes copies whose present bit is low at that time.
- R3: A write to offset 0 while the multicast flag is clear changes only the copy at the selected group and instance. Every other copy keeps its value.
- R4: A read of offset 0 returns the selected copy, and the result is the same whether the multicast flag is set or clear.
- R5: A read of offset 0 returns zero when the selected copy's present bit is low, or when the selected group number is not below NUM_GROUPS. The present bit of group g, instance i is bit g*NUM_INST+i of `present_mask`.
- R6: A unicast write steered to an absent or out-of-range copy is dropped. The copy keeps its earlier value, which becomes readable again once its present bit returns high.
- R7: A read of offset 2 returns 1 and grants the semaphore to the reader when the semaphore is free. A read of offset 2 also returns 1 when the reader already holds it.
- R8: While one requester holds the semaphore, a read of offset 2 by any other requester returns 0, and ownership does not change.
- R9: A write to offset 2 whose bit 0 is 1, made by the holder, frees the semaphore. A write to offset 2 from a non-holder, or with bit 0 equal to 0, leaves the semaphore unchanged.
- R10: A write to offset 1 from a requester that does not hold the semaphore leaves the selector unchanged.
- R11: Every accepted request gives `rsp_valid` high on the following cycle. Write responses and reads of offset 3 return zero data, and `rsp_valid` is low after a cycle with no request.
- R12: A read of offset 1 returns the selector word with all other bits zero. The word has the instance in the low INST_W bits, the group directly above it, and the multicast flag in the top bit. With the default parameters this is instance at bit 0, group at bits 2:1 and multicast at bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W | Requester number |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 2 | Offset: 0 data copies, 1 selector, 2 semaphore, 3 unused |
| req_wdata | input | DATA_W | Write data |
| present_mask | input | NUM_GROUPS*NUM_INST | One bit per copy, high when the unit is present |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_data | output | DATA_W | Read data for the request of the previous cycle |

## Verification
Every result of this block is due exactly one clock edge after the request that causes it. The response data and the response pulse are registered on the edge that accepts the request. Selector, semaphore and copy updates take effect on that same edge, so the next request already sees them. The bench drives each request on a falling edge and samples the response on the next falling edge, which is one rising edge later. It changes `present_mask` only between requests, so each read is decoded against the mask the bench expects.

// File: rtl/steer_pkg.sv
package steer_pkg;
   typedef enum logic [1:0] {
      OFS_COPY = 2'd0,
      OFS_SEL  = 2'd1,
      OFS_SEMA = 2'd2,
      OFS_NONE = 2'd3
   } steer_ofs_e;
endpackage

// File: rtl/steer_sema.sv
module steer_sema #(
   parameter int NUM_REQ = 2,
   parameter int ID_W    = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic            wr_en,
   input  logic            wr_bit0,
   input  logic [ID_W-1:0] req_id,
   output logic            held,
   output logic [ID_W-1:0] owner,
   output logic            holder,
   output logic            grant
);
   if (NUM_REQ < 2) begin : g_bad_req
      $error("steer_sema: NUM_REQ must be at least 2");
   end

   assign holder = held && (owner == req_id);
   assign grant  = !held || holder;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= 1'b0;
         owner <= '0;
      end else if (rd_en && !held) begin
         held  <= 1'b1;
         owner <= req_id;
      end else if (wr_en && holder && wr_bit0) begin
         held  <= 1'b0;
      end
   end
endmodule

// File: rtl/steer_sel.sv
module steer_sel #(
   parameter int DATA_W = 16,
   parameter int GRP_W  = 2,
   parameter int INST_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GRP_W-1:0]  wr_grp,
   input  logic [INST_W-1:0] wr_inst,
   input  logic              wr_mc,
   output logic [GRP_W-1:0]  grp,
   output logic [INST_W-1:0] inst,
   output logic              mc,
   output logic [DATA_W-1:0] word
);
   if (DATA_W < GRP_W + INST_W + 1) begin : g_bad_width
      $error("steer_sel: DATA_W too narrow for selector fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp  <= '0;
         inst <= '0;
         mc   <= 1'b1;
      end else if (wr_en) begin
         grp  <= wr_grp;
         inst <= wr_inst;
         mc   <= wr_mc;
      end
   end

   always_comb begin
      word                     = '0;
      word[INST_W-1:0]         = inst;
      word[INST_W +: GRP_W]    = grp;
      word[DATA_W-1]           = mc;
   end
endmodule

// File: rtl/steer_bank.sv
module steer_bank #(
   parameter int DATA_W     = 16,
   parameter int NUM_GROUPS = 3,
   parameter int NUM_INST   = 2,
   parameter int GRP_W      = 2,
   parameter int INST_W     = 1,
   localparam int NUM_COPIES = NUM_GROUPS * NUM_INST
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  mc,
   input  logic [GRP_W-1:0]      grp,
   input  logic [INST_W-1:0]     inst,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_COPIES-1:0] present,
   output logic [DATA_W-1:0]     rd_data
);
   logic [DATA_W-1:0]     copy_q [NUM_COPIES];
   logic [NUM_COPIES-1:0] hit;

   for (genvar gg = 0; gg < NUM_GROUPS; gg++) begin : g_grp
      for (genvar ii = 0; ii < NUM_INST; ii++) begin : g_inst
         localparam int IDX = gg * NUM_INST + ii;
         assign hit[IDX] = (grp == GRP_W'(gg)) && (inst == INST_W'(ii));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               copy_q[IDX] <= '0;
            else if (wr_en && (mc || (hit[IDX] && present[IDX])))
               copy_q[IDX] <= wdata;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_COPIES; k++)
         if (hit[k] && present[k]) rd_data = copy_q[k];
   end
endmodule

// File: rtl/steer_fabric.sv
module steer_fabric #(
   parameter int DATA_W     = 16,
   parameter int NUM_GROUPS = 3,
   parameter int NUM_INST   = 2,
   parameter int NUM_REQ    = 2,
   localparam int ID_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
   localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) + ((2 ** $clog2(NUM_GROUPS) == NUM_GROUPS) ? 0 : 0) : 1,
   localparam int INST_W     = (NUM_INST > 1) ? $clog2(NUM_INST) : 1,
   localparam int NUM_COPIES = NUM_GROUPS * NUM_INST
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ID_W-1:0]       req_id,
   input  logic                  req_write,
   input  logic [1:0]            req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [NUM_COPIES-1:0] present_mask,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_data
);
   import steer_pkg::*;

   if (NUM_GROUPS < 1 || NUM_INST < 1) begin : g_bad_shape
      $error("steer_fabric: need at least one group and one instance");
   end

   logic              acc_rd, acc_wr;
   logic              sem_held, sem_holder, sem_grant;
   logic [ID_W-1:0]   sem_owner;
   logic [GRP_W-1:0]  sel_grp;
   logic [INST_W-1:0] sel_inst;
   logic              sel_mc;
   logic [DATA_W-1:0] sel_word;
   logic [DATA_W-1:0] bank_rd;
   logic [DATA_W-1:0] rd_mux;

   assign acc_rd = req_valid && !req_write;
   assign acc_wr = req_valid && req_write;

   steer_sema #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_sema (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (acc_rd && (req_addr == OFS_SEMA)),
      .wr_en   (acc_wr && (req_addr == OFS_SEMA)),
      .wr_bit0 (req_wdata[0]),
      .req_id  (req_id),
      .held    (sem_held),
      .owner   (sem_owner),
      .holder  (sem_holder),
      .grant   (sem_grant)
   );

   steer_sel #(.DATA_W(DATA_W), .GRP_W(GRP_W), .INST_W(INST_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_wr && (req_addr == OFS_SEL) && sem_holder),
      .wr_grp  (req_wdata[INST_W +: GRP_W]),
      .wr_inst (req_wdata[INST_W-1:0]),
      .wr_mc   (req_wdata[DATA_W-1]),
      .grp     (sel_grp),
      .inst    (sel_inst),
      .mc      (sel_mc),
      .word    (sel_word)
   );

   steer_bank #(
      .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST),
      .GRP_W(GRP_W), .INST_W(INST_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_wr && (req_addr == OFS_COPY)),
      .mc      (sel_mc),
      .grp     (sel_grp),
      .inst    (sel_inst),
      .wdata   (req_wdata),
      .present (present_mask),
      .rd_data (bank_rd)
   );

   always_comb begin
      rd_mux = '0;
      if (!req_write) begin
         case (req_addr)
            OFS_COPY: rd_mux = bank_rd;
            OFS_SEL:  rd_mux = sel_word;
            OFS_SEMA: rd_mux = DATA_W'(sem_grant);
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_data  <= req_valid ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/steer_fabric_chk.sv
module steer_fabric_chk #(
   parameter int DATA_W     = 16,
   parameter int NUM_GROUPS = 3,
   parameter int NUM_INST   = 2,
   parameter int ID_W       = 1,
   parameter int GRP_W      = 2,
   parameter int INST_W     = 1,
   localparam int NUM_COPIES = NUM_GROUPS * NUM_INST
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [ID_W-1:0]       req_id,
   input logic                  req_write,
   input logic [1:0]            req_addr,
   input logic [DATA_W-1:0]     req_wdata,
   input logic [NUM_COPIES-1:0] present_mask,
   input logic                  rsp_valid,
   input logic [DATA_W-1:0]     rsp_data,
   input logic                  sem_held,
   input logic [ID_W-1:0]       sem_owner,
   input logic [GRP_W-1:0]      sel_grp,
   input logic [INST_W-1:0]     sel_inst,
   input logic                  sel_mc
);
   logic absent_now;
   logic other_holds;

   always_comb begin
      absent_now = 1'b1;
      for (int k = 0; k < NUM_COPIES; k++)
         if ((int'(sel_grp) * NUM_INST + int'(sel_inst)) == k &&
             int'(sel_grp) < NUM_GROUPS && int'(sel_inst) < NUM_INST)
            absent_now = !present_mask[k];
   end

   assign other_holds = sem_held && (sem_owner != req_id);

   assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_absent_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 2'd0 && absent_now) |=> (rsp_data == '0));
   assert_sema_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == 2'd2 && other_holds)
      |=> (rsp_data == '0) && sem_held && $stable(sem_owner));
   assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 2'd1 && !(sem_held && sem_owner == req_id))
      |=> $stable(sel_grp) && $stable(sel_inst) && $stable(sel_mc));
   assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 2'd2 && sem_held && sem_owner == req_id && req_wdata[0])
      |=> !sem_held);
endmodule

bind steer_fabric steer_fabric_chk #(
   .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST),
   .ID_W(ID_W), .GRP_W(GRP_W), .INST_W(INST_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_id       (req_id),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .req_wdata    (req_wdata),
   .present_mask (present_mask),
   .rsp_valid    (rsp_valid),
   .rsp_data     (rsp_data),
   .sem_held     (sem_held),
   .sem_owner    (sem_owner),
   .sel_grp      (sel_grp),
   .sel_inst     (sel_inst),
   .sel_mc       (sel_mc)
);

// File: tb/test_steer_fabric.sv
`timescale 1ns/1ps
module test_steer_fabric;
   localparam int NG = 3;
   localparam int NI = 2;
   localparam int NC = NG * NI;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [0:0]  req_id = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [NC-1:0] present_mask = '1;
   logic        rsp_valid;
   logic [15:0] rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] model [NC];
   logic [15:0] rd;
   logic        rv;

   always #5 clk = ~clk;

   steer_fabric #(.DATA_W(16), .NUM_GROUPS(NG), .NUM_INST(NI), .NUM_REQ(2)) i_steer_fabric (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .present_mask(present_mask), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input int id, input bit wr, input logic [1:0] addr,
                      input logic [15:0] wd, output logic [15:0] r, output logic v);
      req_valid = 1'b1; req_id = id[0]; req_write = wr; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      r = rsp_data; v = rsp_valid;
      req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
   endtask

   function automatic logic [15:0] selw(input bit mc, input int g, input int i);
      return (16'(mc) << 15) | 16'(g << 1) | 16'(i);
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NC; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      check("R1 rsp_valid in reset", 16'(rsp_valid), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rsp_valid idle", 16'(rsp_valid), 16'h0);
      acc(0, 0, 2'd1, 0, rd, rv);
      check("R1 R12 selector after reset", rd, 16'h8000);
      check("R11 read response pulse", 16'(rv), 16'h1);
      @(negedge clk);
      check("R11 idle after response", 16'(rsp_valid), 16'h0);

      // semaphore handshake
      acc(1, 0, 2'd2, 0, rd, rv);  check("R1 R7 free semaphore granted", rd, 16'h1);
      acc(0, 0, 2'd2, 0, rd, rv);  check("R8 other reader denied", rd, 16'h0);
      acc(1, 0, 2'd2, 0, rd, rv);  check("R7 holder reread", rd, 16'h1);
      acc(1, 1, 2'd2, 16'h0, rd, rv);
      check("R11 write response data", rd, 16'h0);
      acc(0, 0, 2'd2, 0, rd, rv);  check("R9 zero write keeps hold", rd, 16'h0);
      acc(0, 1, 2'd2, 16'h1, rd, rv);
      acc(0, 0, 2'd2, 0, rd, rv);  check("R9 non-holder release ignored", rd, 16'h0);
      acc(0, 1, 2'd1, selw(0, 1, 1), rd, rv);
      acc(0, 0, 2'd1, 0, rd, rv);  check("R10 selector locked", rd, 16'h8000);
      acc(1, 1, 2'd2, 16'h1, rd, rv);
      acc(0, 0, 2'd2, 0, rd, rv);  check("R9 R7 release then regrant", rd, 16'h1);
      acc(1, 0, 2'd2, 0, rd, rv);  check("R8 old owner now denied", rd, 16'h0);

      // unicast sweep over all copies
      for (int g = 0; g < NG; g++) begin
         for (int i = 0; i < NI; i++) begin
            acc(0, 1, 2'd1, selw(0, g, i), rd, rv);
            acc(0, 0, 2'd1, 0, rd, rv);
            check("R12 selector readback", rd, selw(0, g, i));
            acc(0, 1, 2'd0, 16'h1000 + 16'(g * 16 + i), rd, rv);
            model[g * NI + i] = 16'h1000 + 16'(g * 16 + i);
         end
      end
      for (int mc = 0; mc < 2; mc++) begin
         for (int g = 0; g < NG; g++) begin
            for (int i = 0; i < NI; i++) begin
               acc(0, 1, 2'd1, selw(mc[0], g, i), rd, rv);
               acc(0, 0, 2'd0, 0, rd, rv);
               check(mc == 0 ? "R3 unicast copy isolated" : "R4 read single copy under multicast",
                     rd, model[g * NI + i]);
            end
         end
      end

      // out-of-range group
      for (int i = 0; i < NI; i++) begin
         acc(0, 1, 2'd1, selw(0, 3, i), rd, rv);
         acc(0, 1, 2'd0, 16'hDEAD, rd, rv);
         acc(0, 0, 2'd0, 0, rd, rv);
         check("R5 out-of-range group reads zero", rd, 16'h0);
      end

      // exhaustive present mask sweep
      for (int m = 0; m < (1 << NC); m++) begin
         present_mask = NC'(m);
         for (int k = 0; k < NC; k++) begin
            acc(0, 1, 2'd1, selw(k[0], k / NI, k % NI), rd, rv);
            acc(0, 0, 2'd0, 0, rd, rv);
            check("R5 present mask read", rd, m[k] ? model[k] : 16'h0);
         end
      end

      // unicast write to absent copy
      present_mask = 6'b111110;
      acc(0, 1, 2'd1, selw(0, 0, 0), rd, rv);
      acc(0, 1, 2'd0, 16'hBEEF, rd, rv);
      present_mask = '1;
      acc(0, 0, 2'd0, 0, rd, rv);
      check("R6 dropped write keeps value", rd, model[0]);
      acc(0, 1, 2'd1, selw(0, 1, 0), rd, rv);
      acc(0, 0, 2'd0, 0, rd, rv);
      check("R6 neighbour untouched", rd, model[2]);

      // multicast write with some copies absent
      present_mask = 6'b010101;
      acc(0, 1, 2'd1, selw(1, 1, 0), rd, rv);
      acc(0, 1, 2'd0, 16'h5A5A, rd, rv);
      check("R11 write response valid", 16'(rv), 16'h1);
      for (int k = 0; k < NC; k++) model[k] = 16'h5A5A;
      present_mask = '1;
      for (int k = 0; k < NC; k++) begin
         acc(0, 1, 2'd1, selw(0, k / NI, k % NI), rd, rv);
         acc(0, 0, 2'd0, 0, rd, rv);
         check("R2 multicast reached copy", rd, model[k]);
      end

      acc(1, 0, 2'd3, 0, rd, rv);
      check("R11 unused offset reads zero", rd, 16'h0);
      @(negedge clk);
      check("R11 idle after unused read", 16'(rsp_valid), 16'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule